// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Seconds Shadow

This block keeps wall time as two free-running counters driven by a 1 kHz tick-enable: a milliseconds count that cycles through 0..999 and a 32-bit seconds count that advances each time the milliseconds count wraps. The clock never stops on its own. It keeps counting for as long as ticks arrive, and nothing outside reset halts it.

Software reads the counters over a small 32-bit read-only register bus. Reading milliseconds and seconds in two separate accesses is racy: seconds can roll over between the two reads. The block removes that race. Every accepted read of the milliseconds register also copies the seconds value of that same cycle into a shadow register. Software reads milliseconds first and then the shadow seconds. From the pair it forms a monotonic value, seconds × 1000 + milliseconds, which advances by 1000 each second.

Top module: `rtc_ms_shadow`

## Requirements
- R1: After a synchronous reset, the milliseconds, live seconds and shadow seconds registers all read 0.
- R2: On each cycle with `tick_1khz` high, milliseconds rises by one. Without a tick, milliseconds and seconds keep their values.
- R3: A tick that arrives while milliseconds is 999 sets milliseconds to 0 and raises seconds by one in the same cycle.
- R4: A read request accepted on a cycle (`rd_en` high) returns, one cycle later, `rd_valid` high and `rd_data` equal to the addressed register as it stood on the accept cycle. `rd_valid` is low on every other cycle.
- R5: An accepted read of the milliseconds register (address 0x10) loads the shadow seconds register (address 0x0C) with the live seconds value of that same cycle. No other read, and no tick, changes the shadow.
- R6: When a milliseconds read and the wrapping tick of R3 fall on the same cycle, the read returns 999 and the shadow receives the seconds value from before the increment. Shadow and milliseconds therefore agree.
- R7: A read of address 0x08 returns the live seconds count, zero-extended to 32 bits.
- R8: A read of any other address returns 0 and disturbs neither the counters nor the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1khz | input | 1 | One-cycle enable per millisecond |
| rd_en | input | 1 | Read request, accepted in the cycle it is high |
| rd_addr | input | 8 | Byte address of the register to read |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle after an accepted read |

## Verification
Two functions can land in one cycle. The first is the wrap of milliseconds from 999 into a new second. The second is the capture of seconds into the shadow that a milliseconds read triggers. The bench counts ticks until milliseconds sits at 999, then asserts the tick and a milliseconds read on the same edge. It expects 999 from that read, the old seconds from the following shadow read, and the new seconds from a live seconds read. Repeated millisecond/shadow read pairs taken across later rollovers must each give the value seconds × 1000 + milliseconds that the bench's own model predicts.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Register byte offsets; software depends on these values
  localparam logic [7:0] OFF_SEC_LIVE   = 8'h08;
  localparam logic [7:0] OFF_SEC_SHADOW = 8'h0C;
  localparam logic [7:0] OFF_MSEC       = 8'h10;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_LIVE   = 2'd1,
    SEL_SHADOW = 2'd2,
    SEL_MSEC   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_W      = 32,
  localparam int MS_W      = $clog2(MS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [MS_W-1:0]  msec,
  output logic [SEC_W-1:0] sec
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic wrap;
  assign wrap = tick && (msec == MS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      msec <= '0;
      sec  <= '0;
    end else if (tick) begin
      if (wrap) begin
        msec <= '0;
        sec  <= sec + 1'b1;
      end else begin
        msec <= msec + 1'b1;
      end
    end
  end

  AST_MS_RANGE: assert property (@(posedge clk) disable iff (rst)
    msec <= MS_LAST); // R3
  AST_MS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(msec) && $stable(sec))); // R2
  AST_MS_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && msec != MS_LAST) |=> (msec == $past(msec) + 1'b1) && $stable(sec)); // R2
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && msec == MS_LAST) |=> (msec == '0) && (sec == $past(sec) + 1'b1)); // R3
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [SEC_W-1:0] sec_live,
  output logic [SEC_W-1:0] sec_shadow
);
  always_ff @(posedge clk) begin
    if (rst)          sec_shadow <= '0;
    else if (capture) sec_shadow <= sec_live;
  end

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    capture |=> sec_shadow == $past(sec_live)); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(sec_shadow)); // R5
endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int MS_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [MS_W-1:0]   msec,
  input  logic [SEC_W-1:0]  sec_live,
  input  logic [SEC_W-1:0]  sec_shadow,
  output logic              capture,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  reg_sel_e sel;

  always_comb begin
    if (rd_addr == ADDR_W'(OFF_SEC_LIVE))        sel = SEL_LIVE;
    else if (rd_addr == ADDR_W'(OFF_SEC_SHADOW)) sel = SEL_SHADOW;
    else if (rd_addr == ADDR_W'(OFF_MSEC))       sel = SEL_MSEC;
    else                                         sel = SEL_NONE;
  end

  assign capture = rd_en && (sel == SEL_MSEC);

  logic [DATA_W-1:0] mux_q;
  always_comb begin
    case (sel)
      SEL_LIVE:   mux_q = DATA_W'(sec_live);
      SEL_SHADOW: mux_q = DATA_W'(sec_shadow);
      SEL_MSEC:   mux_q = DATA_W'(msec);
      default:    mux_q = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mux_q;
    end
  end

  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R4
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> rd_data == '0); // R8
  AST_MS_READ: assert property (@(posedge clk) disable iff (rst)
    capture |=> rd_data == DATA_W'($past(msec))); // R6
endmodule

// File: rtl/rtc_ms_shadow.sv
module rtc_ms_shadow #(
  parameter int MS_PER_SEC = 1000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  localparam int SEC_W     = DATA_W,
  localparam int MS_W      = $clog2(MS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1khz,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [MS_W-1:0]  msec;
  logic [SEC_W-1:0] sec_live;
  logic [SEC_W-1:0] sec_shadow;
  logic             capture;

  rtc_time_count #(.MS_PER_SEC(MS_PER_SEC), .SEC_W(SEC_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick_1khz), .msec(msec), .sec(sec_live)
  );

  rtc_shadow #(.SEC_W(SEC_W)) u_shadow (
    .clk(clk), .rst(rst), .capture(capture),
    .sec_live(sec_live), .sec_shadow(sec_shadow)
  );

  rtc_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .MS_W(MS_W)) u_port (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .msec(msec), .sec_live(sec_live), .sec_shadow(sec_shadow),
    .capture(capture), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/tb_rtc_ms_shadow.sv
module tb_rtc_ms_shadow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1khz = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  rtc_ms_shadow dut (
    .clk(clk), .rst(rst), .tick_1khz(tick_1khz),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench model
  int unsigned m_ms = 0, m_sec = 0, m_shd = 0;

  // driver: one call per cycle; pushes the expected read value
  task automatic step(input logic tk, input logic re, input logic [7:0] a, input string tag);
    @(negedge clk);
    tick_1khz = tk;
    rd_en     = re;
    rd_addr   = a;
    if (re) begin
      case (a)
        8'h08:   exp_q.push_back(m_sec);
        8'h0C:   exp_q.push_back(m_shd);
        8'h10:   exp_q.push_back(m_ms);
        default: exp_q.push_back(32'h0);
      endcase
      tag_q.push_back(tag);
      if (a == 8'h10) m_shd = m_sec;
    end
    if (tk) begin
      if (m_ms == 999) begin m_ms = 0; m_sec = m_sec + 1; end
      else m_ms = m_ms + 1;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, "");
  endtask

  // monitor: compares each returned read against the queue
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R4: rd_valid with no read pending, actual %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          mismatched++;
          $display("FAIL %s: actual %0d expected %0d", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    step(0, 1, 8'h10, "R1 msec");
    step(0, 1, 8'h0C, "R1 shadow");
    step(0, 1, 8'h08, "R1 live");
    // R2: counting and hold
    ticks(5);
    step(0, 1, 8'h10, "R2 msec after 5 ticks");
    step(0, 0, 8'h00, "");
    step(0, 0, 8'h00, "");
    step(0, 1, 8'h10, "R2 msec held without tick");
    // R4: read and tick in same cycle returns pre-tick value
    step(1, 1, 8'h10, "R4 msec on tick cycle");
    step(0, 1, 8'h10, "R4 msec after tick");
    // advance to 999
    ticks(999 - 6);
    step(0, 1, 8'h10, "R2 msec at 999");
    // R6: wrap and capture in the same cycle
    step(1, 1, 8'h10, "R6 msec at wrap");
    step(0, 1, 8'h0C, "R6 shadow old seconds");
    step(0, 1, 8'h08, "R7 live seconds after wrap");
    step(0, 1, 8'h10, "R3 msec zero after wrap");
    step(0, 1, 8'h0C, "R5 shadow seconds after msec read");
    // R8: unmapped reads zero and disturb nothing
    step(0, 1, 8'h04, "R8 unmapped 0x04");
    step(1, 1, 8'h14, "R8 unmapped 0x14");
    step(0, 1, 8'hFF, "R8 unmapped 0xFF");
    step(0, 1, 8'h10, "R8 msec after unmapped");
    // R5: live read or ticks leave shadow alone
    ticks(1200);
    step(0, 1, 8'h08, "R7 live seconds 2");
    step(0, 1, 8'h0C, "R5 shadow unchanged by ticks");
    // paired reads across later rollovers
    for (int k = 0; k < 6; k++) begin
      ticks(337);
      step(1, 1, 8'h10, "R5 paired msec");
      step(1, 1, 8'h0C, "R5 paired shadow");
    end
    ticks(999 - int'(m_ms));
    step(1, 1, 8'h10, "R6 second wrap msec");
    step(0, 1, 8'h0C, "R6 second wrap shadow");
    step(0, 1, 8'h08, "R3 seconds after second wrap");
    step(0, 0, 8'h00, "");
    step(0, 0, 8'h00, "");
    step(0, 0, 8'h00, "");
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R4: actual %0d reads unanswered expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule